// File: doc/BRIEF.md
# One-Hot Selected Parallel ALU

This block is a 16-bit combinational arithmetic logic unit. Every functional unit (a ripple-carry adder shared by addition and subtraction, a bitwise AND, a bitwise XOR, a left shifter, a right shifter and a pass-through of the second operand) produces its answer all the time. One result is chosen by an AND-OR selector driven by one-hot select lines. A small control module decodes the 3-bit opcode into those lines.

Subtraction feeds the inverted second operand into the same adder and sets its carry-in to one. The shifters do not use a mux tree. Each output bit is an OR of the shift-select lines ANDed with the matching input bit, and a decoder makes those one-hot lines from the low four bits of the second operand. The block has no clock and no storage, so the outputs follow the inputs within the same evaluation.

Top module: `onehot_alu`

## Requirements
- R1: Opcode 000 (add) gives result = (opA + opB) mod 2^16, and carryOut = bit 16 of the unsigned sum.
- R2: Opcode 001 (subtract) gives result = (opA - opB) mod 2^16. carryOut = 1 exactly when opA >= opB as unsigned numbers, because it is the carry of opA + ~opB + 1.
- R3: For add and subtract, overflow = 1 exactly when the two's-complement result falls outside -32768..32767.
- R4: For every opcode other than 000 and 001, carryOut and overflow are both 0.
- R5: Opcode 010 gives result = opA AND opB, bit by bit.
- R6: Opcode 011 gives result = opA XOR opB, bit by bit.
- R7: Opcode 100 shifts opA left by opB[3:0] (0 to 15) places and fills with zeros. opB[15:4] has no effect.
- R8: Opcode 101 shifts opA right by opB[3:0] places and fills with zeros (logical shift). opB[15:4] has no effect.
- R9: Opcode 110 gives result = opB.
- R10: Opcode 111 gives result = 0 and both flags 0.
- R11: For opcodes 000 to 110 exactly one unit select line is active, and exactly one shift-select line is always active. The result is therefore one unit's output and never a blend of several.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand; the value that is shifted |
| opB | input | 16 | Second operand; its low four bits give the shift distance |
| opcode | input | 3 | Binary operation code |
| result | output | 16 | Selected unit output |
| carryOut | output | 1 | Adder carry for add and subtract, else 0 |
| overflow | output | 1 | Signed overflow for add and subtract, else 0 |

## Verification
The block holds no state, so a fault inside it shows at the ports in the same evaluation as the stimulus. It cannot stay hidden across cycles. It can still hide behind operand values. A broken carry link only shows when a carry has to travel through that bit, so all-ones plus one and the 0x7FFF/0x8000 boundaries are applied. A decoder line that is stuck active ORs a second unit into the result, so AND and XOR are driven with operands where the two differ. Every shift distance from 0 to 15 is applied with noise in the upper bits of opB, which exposes a wrong shift-select line or a decoder that reads too many bits.

// File: rtl/onehot_alu_pkg.sv
package onehot_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_XOR   = 3'd3,
    OP_SHL   = 3'd4,
    OP_SHR   = 3'd5,
    OP_PASSB = 3'd6,
    OP_NONE  = 3'd7
  } aluOp_e;

  // One-hot unit selects plus the adder's subtract strobe
  typedef struct packed {
    logic invertB;
    logic selArith;
    logic selAnd;
    logic selXor;
    logic selShl;
    logic selShr;
    logic selPass;
  } aluStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import onehot_alu_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [2:0]       opcode,
  input  logic [SHW-1:0]   shAmt,
  output aluStrobes_t      strobes,
  output logic [WIDTH-1:0] shiftSel
);

  // Opcode decoder: at most one unit select line is active
  always_comb begin
    strobes = '0;
    case (aluOp_e'(opcode))
      OP_ADD:   strobes.selArith = 1'b1;
      OP_SUB: begin
        strobes.selArith = 1'b1;
        strobes.invertB  = 1'b1;
      end
      OP_AND:   strobes.selAnd   = 1'b1;
      OP_XOR:   strobes.selXor   = 1'b1;
      OP_SHL:   strobes.selShl   = 1'b1;
      OP_SHR:   strobes.selShr   = 1'b1;
      OP_PASSB: strobes.selPass  = 1'b1;
      default:  strobes = '0;
    endcase
  end

  // Shift-amount decoder: one line per distance
  for (genvar k = 0; k < WIDTH; k++) begin : g_shdec
    assign shiftSel[k] = (shAmt == SHW'(k));
  end

endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             signedOvf
);

  logic [WIDTH:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    // sum bit is odd parity, carry is majority
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (a[i] & carry[i]) | (b[i] & carry[i]);
  end

  assign cout      = carry[WIDTH];
  assign signedOvf = carry[WIDTH] ^ carry[WIDTH-1];

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import onehot_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  input  logic [WIDTH-1:0] shiftSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow
);

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sumRes;
  logic             addCout;
  logic             addOvf;
  logic [WIDTH-1:0] andRes;
  logic [WIDTH-1:0] xorRes;
  logic [WIDTH-1:0] shlRes;
  logic [WIDTH-1:0] shrRes;
  logic [WIDTH-1:0] shlTerm [WIDTH];
  logic [WIDTH-1:0] shrTerm [WIDTH];

  // Subtract reuses the adder: invert B and carry in a one
  assign bEff = opB ^ {WIDTH{strobes.invertB}};

  alu_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .a         (opA),
    .b         (bEff),
    .cin       (strobes.invertB),
    .sum       (sumRes),
    .cout      (addCout),
    .signedOvf (addOvf)
  );

  assign andRes = opA & opB;
  assign xorRes = opA ^ opB;

  // One-hot shifters: bit i ORs select k with the input bit k places away
  for (genvar i = 0; i < WIDTH; i++) begin : g_shbit
    for (genvar k = 0; k < WIDTH; k++) begin : g_shterm
      if (k <= i) begin : g_lhit
        assign shlTerm[i][k] = shiftSel[k] & opA[i-k];
      end else begin : g_lzero
        assign shlTerm[i][k] = 1'b0;
      end
      if (i + k < WIDTH) begin : g_rhit
        assign shrTerm[i][k] = shiftSel[k] & opA[i+k];
      end else begin : g_rzero
        assign shrTerm[i][k] = 1'b0;
      end
    end
    assign shlRes[i] = |shlTerm[i];
    assign shrRes[i] = |shrTerm[i];
  end

  // One-hot AND-OR result selector
  assign result = ({WIDTH{strobes.selArith}} & sumRes)
                | ({WIDTH{strobes.selAnd}}   & andRes)
                | ({WIDTH{strobes.selXor}}   & xorRes)
                | ({WIDTH{strobes.selShl}}   & shlRes)
                | ({WIDTH{strobes.selShr}}   & shrRes)
                | ({WIDTH{strobes.selPass}}  & opB);

  assign carryOut = strobes.selArith & addCout;
  assign overflow = strobes.selArith & addOvf;

endmodule

// File: rtl/onehot_alu.sv
module onehot_alu
  import onehot_alu_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opcode,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow
);

  aluStrobes_t      strobes;
  logic [WIDTH-1:0] shiftSel;

  alu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .opcode   (opcode),
    .shAmt    (opB[SHW-1:0]),
    .strobes  (strobes),
    .shiftSel (shiftSel)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .shiftSel (shiftSel),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow)
  );

endmodule

// File: rtl/onehot_alu_chk.sv
module onehot_alu_chk
  import onehot_alu_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int SHW = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       opcode,
  input logic [WIDTH-1:0] result,
  input logic             carryOut,
  input logic             overflow,
  input aluStrobes_t      strobes,
  input logic [WIDTH-1:0] shiftSel
);

  logic [WIDTH:0] wideSum;
  logic [WIDTH:0] wideDiff;
  logic [5:0]     unitSel;

  assign wideSum  = {1'b0, opA} + {1'b0, opB};
  assign wideDiff = {1'b0, opA} - {1'b0, opB};
  assign unitSel  = {strobes.selArith, strobes.selAnd, strobes.selXor,
                     strobes.selShl, strobes.selShr, strobes.selPass};

  always_comb begin
    if (!$isunknown({opA, opB, opcode})) begin
      if (opcode == 3'd0) begin
        a_r1_add_sum: assert ({carryOut, result} == wideSum)
          else $error("add mismatch");
        a_r3_add_overflow: assert (overflow ==
            ((opA[WIDTH-1] == opB[WIDTH-1]) && (wideSum[WIDTH-1] != opA[WIDTH-1])))
          else $error("add overflow mismatch");
      end
      if (opcode == 3'd1) begin
        a_r2_sub_diff: assert (result == wideDiff[WIDTH-1:0] && carryOut == (opA >= opB))
          else $error("subtract mismatch");
        a_r3_sub_overflow: assert (overflow ==
            ((opA[WIDTH-1] != opB[WIDTH-1]) && (wideDiff[WIDTH-1] != opA[WIDTH-1])))
          else $error("subtract overflow mismatch");
      end
      if (opcode > 3'd1) begin
        a_r4_flags_quiet: assert (!carryOut && !overflow)
          else $error("flags active outside add/subtract");
      end
      if (opcode == 3'd4) begin
        a_r7_shift_left: assert (result == (opA << opB[SHW-1:0]))
          else $error("left shift mismatch");
      end
      if (opcode == 3'd5) begin
        a_r8_shift_right: assert (result == (opA >> opB[SHW-1:0]))
          else $error("right shift mismatch");
      end
      if (opcode == 3'd6) begin
        a_r9_pass_b: assert (result == opB)
          else $error("pass mismatch");
      end
      if (opcode == 3'd7) begin
        a_r10_idle_zero: assert (result == '0 && !carryOut && !overflow)
          else $error("idle code not zero");
      end
      a_r11_unit_onehot: assert ((opcode == 3'd7) ? (unitSel == '0) : $onehot(unitSel))
        else $error("unit select not one-hot");
      a_r11_shift_onehot: assert ($onehot(shiftSel))
        else $error("shift select not one-hot");
    end
  end

endmodule

bind onehot_alu onehot_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opA      (opA),
  .opB      (opB),
  .opcode   (opcode),
  .result   (result),
  .carryOut (carryOut),
  .overflow (overflow),
  .strobes  (strobes),
  .shiftSel (shiftSel)
);

// File: tb/onehot_alu_test.sv
module onehot_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [2:0]  opcode = '0;
  logic [15:0] result;
  logic        carryOut;
  logic        overflow;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk; // 250 MHz

  onehot_alu uut (
    .opA      (opA),
    .opB      (opB),
    .opcode   (opcode),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow)
  );

  // Expected {overflow, carryOut, result} from the requirements
  function automatic logic [17:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic [2:0] op);
    logic [16:0] s;
    logic [16:0] d;
    logic [15:0] r;
    logic        c;
    logic        v;
    c = 1'b0;
    v = 1'b0;
    s = {1'b0, a} + {1'b0, b};
    d = {1'b0, a} + {1'b0, ~b} + 17'd1;
    case (op)
      3'd0: begin r = s[15:0]; c = s[16]; v = (a[15] == b[15]) && (s[15] != a[15]); end
      3'd1: begin r = d[15:0]; c = (a >= b); v = (a[15] != b[15]) && (d[15] != a[15]); end
      3'd2: r = a & b;
      3'd3: r = a ^ b;
      3'd4: r = a << b[3:0];
      3'd5: r = a >> b[3:0];
      3'd6: r = b;
      default: r = 16'h0000;
    endcase
    return {v, c, r};
  endfunction

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0: return "R1/R3";
      3'd1: return "R2/R3";
      3'd2: return "R5/R4";
      3'd3: return "R6/R4";
      3'd4: return "R7/R4";
      3'd5: return "R8/R4";
      3'd6: return "R9/R4";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input string req, input logic [15:0] a, input logic [15:0] b,
                       input logic [2:0] op);
    logic [17:0] exp;
    logic [17:0] act;
    @(negedge clk);
    opA = a;
    opB = b;
    opcode = op;
    #1;
    exp = model(a, b, op);
    act = {overflow, carryOut, result};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, op, a, b, act, exp);
    end
  endtask

  task automatic testReset();
    // R1: all-zero inputs at start give zero result and quiet flags
    apply("R1", 16'h0000, 16'h0000, 3'd0);
  endtask

  task automatic testAdd();
    apply("R1", 16'h1234, 16'h0FED, 3'd0);
    apply("R1", 16'hFFFF, 16'h0001, 3'd0);   // full carry ripple
    apply("R3", 16'h7FFF, 16'h0001, 3'd0);   // positive overflow
    apply("R3", 16'h8000, 16'h8000, 3'd0);   // negative overflow with carry
    apply("R3", 16'hFFFF, 16'hFFFF, 3'd0);   // carry, no overflow
  endtask

  task automatic testSub();
    apply("R2", 16'h0005, 16'h0005, 3'd1);   // equal: carry 1
    apply("R2", 16'h0002, 16'h0005, 3'd1);   // borrow: carry 0
    apply("R2", 16'h0000, 16'hFFFF, 3'd1);
    apply("R3", 16'h8000, 16'h0001, 3'd1);   // overflow
    apply("R3", 16'h7FFF, 16'hFFFF, 3'd1);   // overflow
    apply("R3", 16'h0000, 16'h8000, 3'd1);
  endtask

  task automatic testLogic();
    // R11: AND and XOR differ on these operands, so a blended result shows
    apply("R5", 16'hF0F0, 16'hFF00, 3'd2);
    apply("R5", 16'hFFFF, 16'h8000, 3'd2);
    apply("R6", 16'hF0F0, 16'hFF00, 3'd3);
    apply("R6", 16'hAAAA, 16'hFFFF, 3'd3);
  endtask

  task automatic testShift();
    for (int k = 0; k < 16; k++) begin
      // R7/R8: upper bits of opB are noise and must have no effect
      apply("R7", 16'hB5A3, {12'hA5C, 4'(k)}, 3'd4);
      apply("R8", 16'hB5A3, {12'h3F1, 4'(k)}, 3'd5);
    end
    apply("R7", 16'hFFFF, 16'hFFFF, 3'd4);
    apply("R8", 16'h8000, 16'h000F, 3'd5);
  endtask

  task automatic testPassAndIdle();
    apply("R9", 16'h1111, 16'hC3A5, 3'd6);
    apply("R9", 16'hFFFF, 16'h0000, 3'd6);
    apply("R10", 16'hFFFF, 16'hFFFF, 3'd7);
    apply("R10", 16'h7FFF, 16'h8000, 3'd7);
  endtask

  task automatic testCorners();
    logic [15:0] corner [4];
    corner[0] = 16'h0000;
    corner[1] = 16'h7FFF;
    corner[2] = 16'h8000;
    corner[3] = 16'hFFFF;
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          apply(reqOf(3'(op)), corner[i], corner[j], 3'(op));
  endtask

  task automatic testRandom();
    for (int n = 0; n < 300; n++)
      for (int op = 0; op < 8; op++)
        apply(reqOf(3'(op)), 16'($urandom), 16'($urandom), 3'(op));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    testReset();
    testAdd();
    testSub();
    testLogic();
    testShift();
    testPassAndIdle();
    testCorners();
    testRandom();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule